// File: doc/BRIEF.md
# Scaler Unit Allocator

This block hands out a small pool of scaler units to the users of one display pipe. A user is one of up to 31 planes or the pipe-level fitter, which takes the top user bit. Software first stages requests by setting bits in a user request mask. It then starts an allocation pass. The pass gives every requesting user a scaler index and sets the operating mode of each scaler it touches.

The pass is sequential. It first compares the number of requests with the usable pool size. If there are too many requests, it flags an overflow and changes nothing. Otherwise it visits one user per cycle in ascending bit order. A user that already holds a scaler keeps it. A user without one takes the lowest free scaler. The mode follows a generation flag:
- In legacy mode, a lone request on a pool of more than one scaler is moved onto scaler 0 and runs in high-quality mode.
- In legacy mode with several requests, or with a pool of one, scalers run in dynamic mode.
- In the newer generation, scalers run in normal mode.

Releasing a user frees its scaler. A separate detach request produces one strobe for each present scaler that is left unused, so that the window programming logic can clear it.

Top module: `scaler_alloc`

## Requirements
- R1: After reset the block is idle with `busy`, `done` and `overflow_err` low. The request mask, all valid bits, all in-use bits and the detach strobes are zero, and every scaler mode reads 2'b00.
- R2: While the block is idle and `start` is low, `req_set` bits are ORed into the request mask on the next clock edge.
- R3: While the block is idle and `start` is low, a `req_release` bit clears that user's mask bit and valid bit, and the in-use bit of the scaler it held. Release wins over a set of the same bit in the same cycle.
- R4: A pass whose request count (population of the mask) exceeds the usable pool, min(`pool_size`, 4), ends with `overflow_err` high and no assignment, in-use bit or mode changed. A pass that is not an overflow ends with `overflow_err` low.
- R5: In a pass, users are handled in ascending bit order. A user with a valid id keeps it. A user without one receives the lowest-numbered scaler below the usable pool whose in-use bit is clear, and that bit is set. The id is 3 bits wide at `user_sid[3*i +: 3]`.
- R6: In legacy mode (`legacy_gen`=1), with exactly one request and a usable pool above one, the requesting user ends on scaler 0. The scaler it held before is freed, and scaler 0 gets mode 2'b10 (high quality). No scaler other than 0 ever shows mode 2'b10.
- R7: Otherwise each assigned scaler gets mode 2'b01 (dynamic) in legacy mode, or mode 2'b00 (normal) when `legacy_gen`=0. Scaler k's mode is at `scaler_mode[2*k +: 2]`.
- R8: `busy` rises the cycle after `start` is taken. A normal pass keeps `busy` high for 34 cycles and an overflow pass for 2 cycles. `done` is high for exactly the last of those cycles.
- R9: One cycle after `detach_go` is taken while idle, `detach_strb` pulses for one cycle with a bit for every scaler index below the usable pool whose in-use bit is clear.
- R10: While `busy` is high, `start`, `detach_go`, `req_set` and `req_release` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | 32 | Stage request bits, one per user |
| req_release | input | 32 | Release strobes, one per user |
| start | input | 1 | Begin an allocation pass |
| legacy_gen | input | 1 | 1 selects legacy mode rules (high quality / dynamic) |
| detach_go | input | 1 | Request detach strobes for unused scalers |
| pool_size | input | 3 | Scalers present on the pipe (clipped to 4) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last cycle of a pass |
| overflow_err | output | 1 | Last pass had more requests than scalers |
| user_mask | output | 32 | Current request mask |
| user_sid_vld | output | 32 | User holds a scaler |
| user_sid | output | 96 | Scaler id per user, 3 bits each |
| scaler_busy | output | 4 | In-use bit per scaler |
| scaler_mode | output | 8 | Mode per scaler, 2 bits each |
| detach_strb | output | 4 | Detach strobe per scaler |

## Verification
A corrupted in-use bit shows in the first pass that needs a free scaler: two users then report the same id, or a user gets a higher index than the lowest free one. It also shows at once in the next detach pulse. A stale valid bit after a release shows as a user keeping a scaler that the next pass should have reassigned. The invariant that in-use count equals valid-user count exposes it on the first idle cycle. A wrong pass count or an unclean overflow shows at the `done` pulse of that same pass, as a wrong cycle count or as changed assignments.

// File: rtl/scal_alloc_pkg.sv
package scal_alloc_pkg;
  typedef enum logic [1:0] {
    SM_NORMAL  = 2'b00,
    SM_DYNAMIC = 2'b01,
    SM_HIGHQ   = 2'b10
  } smode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WALK,
    ST_DONE
  } astate_e;
endpackage

// File: rtl/alloc_popcount.sv
module alloc_popcount #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/alloc_first_free.sv
module alloc_first_free #(
  parameter int NS = 4,
  parameter int PW = 3,
  parameter int IW = 2
) (
  input  logic [NS-1:0] in_use,
  input  logic [PW-1:0] pool,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest clear in-use bit below the usable pool
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NS - 1; k >= 0; k--) begin
      if ((k < int'(pool)) && !in_use[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/alloc_detach.sv
module alloc_detach #(
  parameter int NS = 4,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [NS-1:0] in_use,
  input  logic [PW-1:0] pool,
  output logic [NS-1:0] strb
);
  logic [NS-1:0] present;
  logic [NS-1:0] strb_d;
  logic [NS-1:0] strb_q;

  for (genvar k = 0; k < NS; k++) begin : g_present
    assign present[k] = (k < int'(pool));
  end

  always_comb begin
    strb_d = '0;
    if (fire) strb_d = ~in_use & present;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= '0;
    else        strb_q <= strb_d;
  end

  assign strb = strb_q;
endmodule

// File: rtl/scaler_alloc.sv
module scaler_alloc
  import scal_alloc_pkg::*;
#(
  parameter  int NU    = 32,
  parameter  int NS    = 4,
  localparam int IW    = (NS > 1) ? $clog2(NS) : 1,
  localparam int SID_W = IW + 1,
  localparam int PW    = $clog2(NS + 1),
  localparam int CW    = $clog2(NU + 1),
  localparam int XW    = $clog2(NU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NU-1:0]     req_set,
  input  logic [NU-1:0]     req_release,
  input  logic              start,
  input  logic              legacy_gen,
  input  logic              detach_go,
  input  logic [PW-1:0]     pool_size,
  output logic              busy,
  output logic              done,
  output logic              overflow_err,
  output logic [NU-1:0]     user_mask,
  output logic [NU-1:0]     user_sid_vld,
  output logic [NU*SID_W-1:0] user_sid,
  output logic [NS-1:0]     scaler_busy,
  output logic [NS*2-1:0]   scaler_mode,
  output logic [NS-1:0]     detach_strb
);

  astate_e          state_q, state_d;
  logic [XW-1:0]    idx_q, idx_d;
  logic [CW-1:0]    need_q, need_d;
  logic [PW-1:0]    pool_q, pool_d;
  logic             legacy_q, legacy_d;
  logic             err_q, err_d;
  logic [NU-1:0]    mask_q, mask_d;
  logic [NU-1:0]    vld_q, vld_d;
  logic [SID_W-1:0] sid_q [NU];
  logic [SID_W-1:0] sid_d [NU];
  logic [NS-1:0]    inuse_q, inuse_d;
  smode_e           mode_q [NS];
  smode_e           mode_d [NS];

  logic [PW-1:0]    pool_eff;
  logic [CW-1:0]    req_cnt;
  logic             free_found;
  logic [IW-1:0]    free_idx;
  logic             idle;
  logic             take_start;
  logic             take_edit;
  logic             lone_hq;
  logic             have;
  logic [IW-1:0]    pick;

  assign idle       = (state_q == ST_IDLE);
  assign take_start = idle && start;
  assign take_edit  = idle && !start;
  assign pool_eff   = (int'(pool_size) > NS) ? PW'(NS) : pool_size;
  assign lone_hq    = legacy_q && (need_q == CW'(1)) && (int'(pool_q) > 1);

  alloc_popcount #(.W(NU), .CW(CW)) u_count (
    .vec (mask_q),
    .cnt (req_cnt)
  );

  alloc_first_free #(.NS(NS), .PW(PW), .IW(IW)) u_free (
    .in_use (inuse_q),
    .pool   (pool_q),
    .found  (free_found),
    .idx    (free_idx)
  );

  alloc_detach #(.NS(NS), .PW(PW)) u_detach (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (idle && detach_go),
    .in_use (inuse_q),
    .pool   (pool_eff),
    .strb   (detach_strb)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    need_d   = need_q;
    pool_d   = pool_q;
    legacy_d = legacy_q;
    err_d    = err_q;
    mask_d   = mask_q;
    vld_d    = vld_q;
    inuse_d  = inuse_q;
    have     = 1'b0;
    pick     = '0;
    for (int i = 0; i < NU; i++) sid_d[i] = sid_q[i];
    for (int k = 0; k < NS; k++) mode_d[k] = mode_q[k];

    unique case (state_q)
      ST_IDLE: begin
        if (take_start) begin
          state_d  = ST_CHECK;
          need_d   = req_cnt;
          pool_d   = pool_eff;
          legacy_d = legacy_gen;
          err_d    = 1'b0;
        end else if (take_edit) begin
          mask_d = (mask_q | req_set) & ~req_release;
          for (int i = 0; i < NU; i++) begin
            if (req_release[i] && vld_q[i]) begin
              vld_d[i] = 1'b0;
              inuse_d[sid_q[i][IW-1:0]] = 1'b0;
            end
          end
        end
      end
      ST_CHECK: begin
        if (int'(need_q) > int'(pool_q)) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          idx_d   = '0;
          state_d = ST_WALK;
        end
      end
      ST_WALK: begin
        if (mask_q[idx_q]) begin
          if (vld_q[idx_q]) begin
            have = 1'b1;
            pick = sid_q[idx_q][IW-1:0];
          end else if (free_found) begin
            have = 1'b1;
            pick = free_idx;
          end
          if (have) begin
            vld_d[idx_q] = 1'b1;
            if (lone_hq) begin
              inuse_d[pick] = 1'b0;
              inuse_d[0]    = 1'b1;
              sid_d[idx_q]  = '0;
              mode_d[0]     = SM_HIGHQ;
            end else begin
              inuse_d[pick] = 1'b1;
              sid_d[idx_q]  = {1'b0, pick};
              mode_d[pick]  = legacy_q ? SM_DYNAMIC : SM_NORMAL;
            end
          end
        end
        if (idx_q == XW'(NU - 1)) state_d = ST_DONE;
        else                      idx_d   = idx_q + XW'(1);
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      need_q   <= '0;
      pool_q   <= '0;
      legacy_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
      if (take_start) begin
        need_q   <= need_d;
        pool_q   <= pool_d;
        legacy_q <= legacy_d;
      end
    end
  end

  // allocation table registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      vld_q   <= '0;
      inuse_q <= '0;
      for (int i = 0; i < NU; i++) sid_q[i] <= '0;
      for (int k = 0; k < NS; k++) mode_q[k] <= SM_NORMAL;
    end else begin
      mask_q  <= mask_d;
      vld_q   <= vld_d;
      inuse_q <= inuse_d;
      for (int i = 0; i < NU; i++) sid_q[i] <= sid_d[i];
      for (int k = 0; k < NS; k++) mode_q[k] <= mode_d[k];
    end
  end

  for (genvar i = 0; i < NU; i++) begin : g_sid_out
    assign user_sid[i*SID_W +: SID_W] = sid_q[i];
  end
  for (genvar k = 0; k < NS; k++) begin : g_mode_out
    assign scaler_mode[2*k +: 2] = mode_q[k];
  end

  assign busy         = !idle;
  assign done         = (state_q == ST_DONE);
  assign overflow_err = err_q;
  assign user_mask    = mask_q;
  assign user_sid_vld = vld_q;
  assign scaler_busy  = inuse_q;
endmodule

// File: rtl/scaler_alloc_chk.sv
module scaler_alloc_chk #(
  parameter int NU = 32,
  parameter int NS = 4,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          overflow_err,
  input logic [PW-1:0] pool_size,
  input logic [NU-1:0] user_mask,
  input logic [NU-1:0] user_sid_vld,
  input logic [NS-1:0] scaler_busy,
  input logic [NS*2-1:0] scaler_mode,
  input logic [NS-1:0] detach_strb
);
  int  usable;
  logic hq_off_zero;

  assign usable = (int'(pool_size) > NS) ? NS : int'(pool_size);

  always_comb begin
    hq_off_zero = 1'b0;
    for (int k = 1; k < NS; k++) begin
      if (scaler_mode[2*k +: 2] == 2'b10) hq_off_zero = 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R8
  AST_DONE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);  // R8
  AST_VALID_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((user_sid_vld & ~user_mask) == '0));  // R3
  AST_INUSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ($countones(scaler_busy) == $countones(user_sid_vld)));  // R5
  AST_DETACH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ((detach_strb & scaler_busy) == '0));  // R9
  AST_HQ_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hq_off_zero);  // R6
  AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow_err) |-> ($countones(user_mask) > usable));  // R4
endmodule

bind scaler_alloc scaler_alloc_chk #(.NU(NU), .NS(NS), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .overflow_err (overflow_err),
  .pool_size    (pool_size),
  .user_mask    (user_mask),
  .user_sid_vld (user_sid_vld),
  .scaler_busy  (scaler_busy),
  .scaler_mode  (scaler_mode),
  .detach_strb  (detach_strb)
);

// File: tb/scaler_alloc_test.sv
module scaler_alloc_test;
  localparam int NU = 32;
  localparam int NS = 4;

  logic        clk;
  logic        rst_n;
  logic [31:0] req_set, req_release;
  logic        start, legacy_gen, detach_go;
  logic [2:0]  pool_size;
  logic        busy, done, overflow_err;
  logic [31:0] user_mask, user_sid_vld;
  logic [95:0] user_sid;
  logic [3:0]  scaler_busy;
  logic [7:0]  scaler_mode;
  logic [3:0]  detach_strb;

  scaler_alloc #(.NU(NU), .NS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_release(req_release),
    .start(start), .legacy_gen(legacy_gen), .detach_go(detach_go),
    .pool_size(pool_size), .busy(busy), .done(done),
    .overflow_err(overflow_err), .user_mask(user_mask),
    .user_sid_vld(user_sid_vld), .user_sid(user_sid),
    .scaler_busy(scaler_busy), .scaler_mode(scaler_mode),
    .detach_strb(detach_strb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // reference model
  logic [31:0] m_mask, m_vld;
  int          m_sid [32];
  logic [3:0]  m_inuse;
  logic [1:0]  m_mode [4];
  logic        m_err;
  logic [31:0] lf;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_state(input string req);
    chk(req, "mask", 64'(user_mask), 64'(m_mask));
    chk(req, "valid", 64'(user_sid_vld), 64'(m_vld));
    chk(req, "in_use", 64'(scaler_busy), 64'(m_inuse));
    chk(req, "error", 64'(overflow_err), 64'(m_err));
    for (int k = 0; k < 4; k++)
      chk(req, $sformatf("mode%0d", k), 64'(scaler_mode[2*k +: 2]), 64'(m_mode[k]));
    for (int i = 0; i < 32; i++)
      if (m_vld[i])
        chk(req, $sformatf("sid%0d", i), 64'(user_sid[3*i +: 3]), 64'(m_sid[i]));
  endtask

  function automatic int peff(input int p);
    return (p > 4) ? 4 : p;
  endfunction

  task automatic model_release(input logic [31:0] bits);
    for (int i = 0; i < 32; i++)
      if (bits[i] && m_vld[i]) begin
        m_inuse[m_sid[i]] = 1'b0;
        m_vld[i] = 1'b0;
      end
    m_mask = m_mask & ~bits;
  endtask

  task automatic model_run(input int pool, input bit leg);
    int need, pe, pick;
    need = $countones(m_mask);
    pe = peff(pool);
    if (need > pe) begin
      m_err = 1'b1;
      return;
    end
    m_err = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (m_mask[i]) begin
        pick = -1;
        if (m_vld[i]) pick = m_sid[i];
        else
          for (int k = pe - 1; k >= 0; k--) if (!m_inuse[k]) pick = k;
        if (pick >= 0) begin
          m_vld[i] = 1'b1;
          if (leg && need == 1 && pe > 1) begin
            m_inuse[pick] = 1'b0;
            m_inuse[0] = 1'b1;
            m_sid[i] = 0;
            m_mode[0] = 2'b10;
          end else begin
            m_inuse[pick] = 1'b1;
            m_sid[i] = pick;
            m_mode[pick] = leg ? 2'b01 : 2'b00;
          end
        end
      end
    end
  endtask

  task automatic op_edit(input logic [31:0] s, input logic [31:0] r, input string req);
    req_set = s;
    req_release = r;
    @(negedge clk);
    req_set = '0;
    req_release = '0;
    m_mask = m_mask | s;
    model_release(r);
    cmp_state(req);
  endtask

  task automatic op_run(input int pool, input bit leg, input string req);
    int cnt, expc, pe;
    pe = peff(pool);
    expc = ($countones(m_mask) > pe) ? 2 : NU + 2;
    pool_size = 3'(pool);
    legacy_gen = leg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk("R8", "run length", 64'(cnt), 64'(expc));
    model_run(pool, leg);
    cmp_state(req);
    @(negedge clk);
    chk("R8", "idle after done", 64'(busy), 64'd0);
  endtask

  task automatic op_detach(input int pool);
    logic [3:0] exp;
    int pe;
    pe = peff(pool);
    exp = '0;
    for (int k = 0; k < 4; k++) if (k < pe && !m_inuse[k]) exp[k] = 1'b1;
    pool_size = 3'(pool);
    detach_go = 1'b1;
    @(negedge clk);
    detach_go = 1'b0;
    chk("R9", "detach strobe", 64'(detach_strb), 64'(exp));
    @(negedge clk);
    chk("R9", "detach pulse width", 64'(detach_strb), 64'd0);
  endtask

  task automatic lf_step();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_set = '0; req_release = '0;
    start = 1'b0; legacy_gen = 1'b0; detach_go = 1'b0; pool_size = 3'd4;
    m_mask = '0; m_vld = '0; m_inuse = '0; m_err = 1'b0;
    for (int i = 0; i < 32; i++) m_sid[i] = 0;
    for (int k = 0; k < 4; k++) m_mode[k] = 2'b00;
    lf = 32'h1ACE_5EED;
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp_state("R1");
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "detach", 64'(detach_strb), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 staging, R5 ascending assignment, R7 normal mode
    op_edit(32'h0000_0021, '0, "R2");
    op_run(4, 1'b0, "R5");
    // R7 dynamic mode keeps ids
    op_run(4, 1'b1, "R7");
    // R4 overflow with 4 requests on 3 scalers, and on pool 0
    op_edit(32'h8000_0004, '0, "R2");
    op_run(3, 1'b1, "R4");
    op_run(0, 1'b0, "R4");
    // pool above range clipped to 4
    op_run(7, 1'b1, "R5");
    op_detach(4);
    // R3 release frees scalers, R9 strobes the free ones
    op_edit('0, 32'h0000_0005, "R3");
    op_detach(4);
    op_detach(1);
    // R3 release wins over set
    op_edit(32'h0000_0020, 32'h0000_0020, "R3");
    // R6 lone request moves to scaler 0 in high quality
    op_run(4, 1'b1, "R6");
    op_detach(4);
    // R7 pool of one: no high quality
    op_edit('0, 32'h8000_0000, "R3");
    op_edit(32'h0000_0400, '0, "R2");
    op_run(1, 1'b1, "R7");

    // R10 inputs ignored while busy
    op_edit(32'h0000_000A, '0, "R2");
    pool_size = 3'd4;
    legacy_gen = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    req_set = 32'hFFFF_FFFF;
    req_release = 32'hFFFF_FFFF;
    detach_go = 1'b1;
    begin
      int cnt;
      cnt = 1;
      while (!done && cnt < 100) begin
        if (cnt > 1)
          chk("R10", "detach while busy", 64'(detach_strb), 64'd0);
        start = (cnt < 5);
        @(negedge clk);
        cnt++;
      end
      chk("R8", "run length", 64'(cnt), 64'(NU + 2));
    end
    req_set = '0; req_release = '0; detach_go = 1'b0; start = 1'b0;
    model_run(4, 1'b0);
    cmp_state("R10");
    @(negedge clk);
    chk("R10", "no restart", 64'(busy), 64'd0);
    cmp_state("R10");

    // near-exhaustive sweep of operation mixes
    for (int n = 0; n < 400; n++) begin
      lf_step();
      case (lf[2:0])
        3'd0, 3'd1: op_edit((32'h1 << lf[7:3]) | (32'h1 << lf[12:8]), '0, "R2");
        3'd2:       op_edit('0, m_mask & lf, "R3");
        3'd3:       op_edit(32'h1 << lf[17:13], m_mask & {lf[15:0], lf[31:16]}, "R3");
        3'd4, 3'd5: op_run(int'(lf[20:18]) % 6, lf[21], "R5");
        3'd6:       op_detach(int'(lf[24:22]) % 6);
        default:    op_run(4, lf[25], "R6");
      endcase
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule